// File: doc/BRIEF.md
# Card Fault Supervisor and Power-Down Sequencer

This block guards a smart card socket. It debounces the card-presence switch and filters six digital fault comparator inputs through a cycle-count timeout. The six inputs are supply undervoltage, supply overcurrent, reset-pin mismatch, clock-pin mismatch, overtemperature and external supply undervoltage. A qualified fault, a card pulled out during a session, or a request for power with no card in the socket is latched as a fault.

When the supply command returns to off, or when a fault is latched, the block walks the card pins down in a fixed order: reset low, then clock low, then the data pins low, then supply off. The clock step depends on the card type. For an asynchronous card the clock runs until its next low level, and a timeout bounds the wait. For a synchronous card the clock is frozen at its present level for a full timeout and then parked low.

All card signal drives are held low while the supply is not yet reported ready. Fault bits stay latched until the host commands the supply off, and an active-low flag mirrors the summary fault bit.

Top module: `card_fault_sequencer`

## Requirements
- R1: `st_present` rises only at the clock edge where `card_present` has been sampled high on DEBOUNCE_CYC consecutive edges. A single low sample restarts the count and clears `st_present` at the next edge.
- R2: A filtered fault input (`flt_raw` bits 0 vcc undervoltage, 1 overcurrent, 2 reset mismatch, 4 overtemperature, 5 external undervoltage) latches its cause bit, at the same position in `fault_cause`, at the edge of its TIMEOUT_CYC-th consecutive high sample. A shorter pulse has no effect, and a low sample restarts its count.
- R3: The clock-mismatch input (`flt_raw` bit 3) sums its high samples across low gaps and latches `fault_cause` bit 3 at the edge where the total reaches TIMEOUT_CYC. Its sum clears only while the supply command is off.
- R4: While the supply command is on, `card_present` low or `st_present` low latches `fault_cause` bit 6 at the next edge. This covers both removal during a session and power requested with no card. In the second case `vcc_en` never rises.
- R5: Cause bits and `st_fault` (the OR of all cause bits) hold while `vcc_sel` is nonzero and clear at the first edge with `vcc_sel` = 0. `fault_n` is the inverse of `st_fault`.
- R6: A power-down starts at the edge where `vcc_sel` is 0 or a fault is latched. From that edge `card_rst` is low.
- R7: With `async_mode` = 1 during the clock step, `card_clk` follows `clk_in` until `clk_in` is low. The step ends at that edge. If `clk_in` stays high, the step ends after TIMEOUT_CYC cycles.
- R8: With `async_mode` = 0, `card_clk` keeps the level it had at the power-down edge for exactly TIMEOUT_CYC cycles, whatever `clk_in` does, and is then low.
- R9: One cycle after the clock step ends, `sig_en` and `card_clk` are low while `vcc_en` is still high. One cycle after that, `vcc_en` is low.
- R10: `card_rst`, `card_clk` and `sig_en` are low whenever `vcc_ready` is low.
- R11: With the supply off, `vcc_sel` nonzero and no fault, `vcc_en` rises at the next edge. From then on, with `vcc_ready` high, `card_rst` follows `host_rst`, `card_clk` follows `clk_in` and `sig_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_present | input | 1 | Raw presence switch, high when a card is seated |
| vcc_sel | input | 2 | Supply command, 0 means off, any other value means on |
| async_mode | input | 1 | 1 for an asynchronous card clock, 0 for a synchronous one |
| vcc_ready | input | 1 | Card supply has reached its final value |
| host_rst | input | 1 | Reset level requested by the host |
| clk_in | input | 1 | Card clock from the clock selector |
| flt_raw | input | 6 | Fault comparator outputs, bit positions as in R2 and R3 |
| vcc_en | output | 1 | Card supply enable |
| card_rst | output | 1 | Drive for the card reset pin |
| card_clk | output | 1 | Drive for the card clock pin |
| sig_en | output | 1 | Enable for the data pins; low forces them low |
| st_present | output | 1 | Debounced card presence status |
| st_fault | output | 1 | Summary fault status bit |
| fault_n | output | 1 | Active-low fault flag, inverse of st_fault |
| fault_cause | output | 7 | Latched fault causes, bits 0 to 5 as flt_raw, bit 6 no card |

## Verification
The bench drives presence glitches one sample short of the debounce period. A counter that fired early or did not restart would report a card that is not there. It also sends fault pulses one cycle short of the timeout and clock-mismatch bursts split by gaps. A filter that did not restart would power a card down on noise, and one that restarted on the clock mismatch would never catch a free-running clock error. During the synchronous clock step it toggles `clk_in`, so a sequencer that leaked the clock or left the step one cycle off would show it on `card_clk`. It also requests power with the socket empty, so an ordering slip between the no-card check and the supply enable would show a brief `vcc_en` pulse.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int N_ELEC      = 6;          // filtered comparator inputs
  localparam int N_CAUSE     = N_ELEC + 1; // plus the no-card cause
  localparam int IDX_CLK_MIS = 3;          // accumulating input
  localparam int IDX_NOCARD  = 6;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_CLKDN = 2'd2,
    ST_SIGDN = 2'd3
  } seq_state_e;

  // saturating increment shared by the debounce and fault counters
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/cfs_presence_debounce.sv
module cfs_presence_debounce import cfs_pkg::*; #(
  parameter int DEBOUNCE_CYC = 6_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic present
);
  localparam int CW  = $clog2(DEBOUNCE_CYC + 1);
  localparam int LIM = DEBOUNCE_CYC - 1;

  logic [CW-1:0] cnt;
  logic          full_run;   // this sample completes the continuous run

  assign full_run = raw && (int'(cnt) == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      present <= 1'b0;
    end else if (raw) begin
      cnt     <= CW'(sat_inc(int'(cnt), LIM));
      present <= present | full_run;
    end else begin
      cnt     <= '0;
      present <= 1'b0;
    end
  end

  assert_rise_needs_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(raw));
  assert_drop_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !present);
endmodule

// File: rtl/cfs_fault_filter.sv
module cfs_fault_filter import cfs_pkg::*; #(
  parameter int TIMEOUT_CYC = 1000,
  parameter bit ACCUM       = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic raw,
  output logic qual
);
  localparam int CW  = $clog2(TIMEOUT_CYC + 1);
  localparam int LIM = TIMEOUT_CYC - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_idle;   // counter value on a low sample

  assign qual = raw && !clr && (int'(cnt) == LIM);

  generate
    if (ACCUM) begin : g_accum
      assign cnt_idle = cnt;
      assert_accum_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw && !clr) |=> (cnt == $past(cnt)));
    end else begin : g_restart
      assign cnt_idle = '0;
      assert_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(raw));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (raw)    cnt <= CW'(sat_inc(int'(cnt), LIM));
    else             cnt <= cnt_idle;
  end
endmodule

// File: rtl/cfs_deact_seq.sv
module cfs_deact_seq import cfs_pkg::*; #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic fault_now,
  input  logic async_mode,
  input  logic vcc_ready,
  input  logic host_rst,
  input  logic clk_in,
  output logic vcc_en,
  output logic rst_o,
  output logic clk_o,
  output logic sig_en
);
  localparam int CW  = $clog2(TIMEOUT_CYC + 1);
  localparam int LIM = TIMEOUT_CYC - 1;

  seq_state_e    st;
  logic [CW-1:0] tmr;
  logic          clk_frz;
  logic          go, stop, clk_done, tmr_out;

  assign go       = cmd_on && !fault_now;
  assign stop     = !cmd_on || fault_now;
  assign tmr_out  = (int'(tmr) == LIM);
  assign clk_done = (async_mode && !clk_in) || tmr_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      tmr     <= '0;
      clk_frz <= 1'b0;
    end else begin
      case (st)
        ST_OFF:   if (go) st <= ST_ON;
        ST_ON: begin
          clk_frz <= clk_o;
          if (stop) begin
            st  <= ST_CLKDN;
            tmr <= '0;
          end
        end
        ST_CLKDN: begin
          tmr <= tmr + 1'b1;
          if (clk_done) st <= ST_SIGDN;
        end
        default:  st <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    vcc_en = (st != ST_OFF);
    sig_en = vcc_ready && (st == ST_ON || st == ST_CLKDN);
    rst_o  = vcc_ready && (st == ST_ON) && host_rst;
    clk_o  = vcc_ready && (((st == ST_ON) && clk_in) ||
                           ((st == ST_CLKDN) && (async_mode ? clk_in : clk_frz)));
  end

  assert_gate_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ready |-> (!rst_o && !clk_o && !sig_en));
  assert_rst_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && stop) |=> !rst_o);
  assert_sync_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLKDN && $past(st) == ST_CLKDN && !async_mode && $stable(vcc_ready))
      |-> $stable(clk_o));
  assert_async_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLKDN && async_mode && !clk_in) |=> !clk_o);
  assert_step_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SIGDN) |-> ($past(st) == ST_CLKDN));
  assert_vcc_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> $past(!sig_en));
endmodule

// File: rtl/card_fault_sequencer.sv
module card_fault_sequencer import cfs_pkg::*; #(
  parameter int DEBOUNCE_CYC = 6_400_000, // 32 ms at 200 MHz
  parameter int TIMEOUT_CYC  = 1000       // 5 us at 200 MHz
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               card_present,
  input  logic [1:0]         vcc_sel,
  input  logic               async_mode,
  input  logic               vcc_ready,
  input  logic               host_rst,
  input  logic               clk_in,
  input  logic [N_ELEC-1:0]  flt_raw,
  output logic               vcc_en,
  output logic               card_rst,
  output logic               card_clk,
  output logic               sig_en,
  output logic               st_present,
  output logic               st_fault,
  output logic               fault_n,
  output logic [N_CAUSE-1:0] fault_cause
);
  logic               cmd_on;
  logic [N_CAUSE-1:0] evt;        // cause events seen this cycle
  logic               fault_now;

  assign cmd_on = (vcc_sel != 2'b00);

  cfs_presence_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(card_present), .present(st_present)
  );

  generate
    for (genvar g = 0; g < N_ELEC; g++) begin : g_flt
      cfs_fault_filter #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .ACCUM(g == IDX_CLK_MIS)
      ) u_flt (
        .clk(clk), .rst_n(rst_n), .clr(!cmd_on), .raw(flt_raw[g]), .qual(evt[g])
      );
    end
  endgenerate

  assign evt[IDX_NOCARD] = cmd_on && (!card_present || !st_present);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_cause <= '0;
    else if (!cmd_on) fault_cause <= '0;
    else              fault_cause <= fault_cause | evt;
  end

  assign st_fault  = |fault_cause;
  assign fault_n   = !st_fault;
  assign fault_now = st_fault || (|evt);

  cfs_deact_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .fault_now(fault_now),
    .async_mode(async_mode), .vcc_ready(vcc_ready), .host_rst(host_rst),
    .clk_in(clk_in), .vcc_en(vcc_en), .rst_o(card_rst), .clk_o(card_clk),
    .sig_en(sig_en)
  );

  assert_nocard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && !card_present) |=> st_fault);
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && $past(cmd_on) && $past(st_fault)) |-> st_fault);
  assert_clear_on_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> (fault_cause == '0));
endmodule

// File: tb/card_fault_sequencer_tb_top.sv
module card_fault_sequencer_tb_top;
  localparam int DEB = 16;
  localparam int TMO = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_present = 1'b0;
  logic [1:0] vcc_sel = 2'b00;
  logic       async_mode = 1'b0;
  logic       vcc_ready = 1'b0;
  logic       host_rst = 1'b0;
  logic       clk_in = 1'b0;
  logic [5:0] flt_raw = '0;
  logic       vcc_en, card_rst, card_clk, sig_en, st_present, st_fault, fault_n;
  logic [6:0] fault_cause;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  card_fault_sequencer #(.DEBOUNCE_CYC(DEB), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .card_present(card_present), .vcc_sel(vcc_sel),
    .async_mode(async_mode), .vcc_ready(vcc_ready), .host_rst(host_rst),
    .clk_in(clk_in), .flt_raw(flt_raw), .vcc_en(vcc_en), .card_rst(card_rst),
    .card_clk(card_clk), .sig_en(sig_en), .st_present(st_present),
    .st_fault(st_fault), .fault_n(fault_n), .fault_cause(fault_cause)
  );

  // expected one-hot cause word for a source index
  function automatic int cause_of(input int idx);
    return 1 << idx;
  endfunction

  // expected gated drive value
  function automatic int gated(input logic rdy, input logic v);
    return int'(rdy & v);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int idx;
    int total;
    int run;
    int srcs[5] = '{0, 1, 2, 4, 5};
    void'($urandom(32'd4242));

    tick(3);
    chk("reset vcc_en R9", vcc_en, 0);
    chk("reset fault_n R5", fault_n, 1);
    chk("reset present R1", st_present, 0);
    rst_n = 1'b1;
    tick(1);

    // R1: glitches shorter than the debounce period
    for (int i = 0; i < 12; i++) begin
      card_present = 1'b1;
      tick($urandom_range(1, DEB - 1));
      chk("R1 short run", st_present, 0);
      card_present = 1'b0;
      tick(1);
      chk("R1 after drop", st_present, 0);
    end
    card_present = 1'b1;
    tick(DEB - 1);
    chk("R1 one short", st_present, 0);
    tick(1);
    chk("R1 full run", st_present, 1);

    // R11 / R10: activation and gating
    async_mode = 1'b0; host_rst = 1'b1; clk_in = 1'b1; vcc_ready = 1'b0;
    vcc_sel = 2'b10;
    tick(1);
    chk("R11 vcc_en up", vcc_en, 1);
    chk("R10 rst gated", card_rst, 0);
    chk("R10 clk gated", card_clk, 0);
    chk("R10 sig gated", sig_en, 0);
    for (int i = 0; i < 16; i++) begin
      vcc_ready = 1'($urandom_range(0, 1));
      host_rst  = 1'($urandom_range(0, 1));
      clk_in    = 1'($urandom_range(0, 1));
      #1;
      chk("R11 rst follow", card_rst, gated(vcc_ready, host_rst));
      chk("R11 clk follow", card_clk, gated(vcc_ready, clk_in));
      chk("R10 sig_en", sig_en, int'(vcc_ready));
      tick(1);
    end
    vcc_ready = 1'b1; host_rst = 1'b1; clk_in = 1'b1;
    tick(1);

    // R2: filtered fault, then R6 / R8 / R9 sync power-down
    idx = srcs[$urandom_range(0, 4)];
    flt_raw[idx] = 1'b1;
    tick(TMO - 1);
    chk("R2 short pulse", st_fault, 0);
    chk("R2 still powered", vcc_en, 1);
    flt_raw = '0;
    tick(1);
    chk("R2 restart", st_fault, 0);
    flt_raw[idx] = 1'b1;
    tick(TMO - 1);
    chk("R2 one short", st_fault, 0);
    tick(1);
    chk("R2 latched", st_fault, 1);
    chk("R2 cause", int'(fault_cause), cause_of(idx));
    chk("R5 fault_n", fault_n, 0);
    chk("R6 rst low", card_rst, 0);
    flt_raw = '0;
    for (int k = 0; k < TMO; k++) begin
      clk_in = k[0];
      #1;
      chk("R8 frozen clk", card_clk, 1);
      chk("R9 sig during clk step", sig_en, 1);
      tick(1);
    end
    chk("R8 clk parked", card_clk, 0);
    chk("R9 sig low", sig_en, 0);
    chk("R9 vcc still on", vcc_en, 1);
    tick(1);
    chk("R9 vcc off", vcc_en, 0);
    tick(3);
    chk("R5 held off", vcc_en, 0);
    chk("R5 still latched", st_fault, 1);
    vcc_sel = 2'b00;
    tick(1);
    chk("R5 cleared", int'(fault_cause), 0);
    chk("R5 fault_n clear", fault_n, 1);

    // R3: accumulating clock mismatch, then R7 async park on low
    async_mode = 1'b1; clk_in = 1'b1; vcc_sel = 2'b11;
    tick(2);
    total = 0;
    while (total < TMO - 1) begin
      run = $urandom_range(1, 3);
      if (run > TMO - 1 - total) run = TMO - 1 - total;
      flt_raw[3] = 1'b1;
      tick(run);
      total += run;
      chk("R3 partial sum", st_fault, 0);
      flt_raw[3] = 1'b0;
      tick($urandom_range(1, 4));
      chk("R3 gap keeps", st_fault, 0);
    end
    flt_raw[3] = 1'b1;
    tick(1);
    chk("R3 latched", st_fault, 1);
    chk("R3 cause", int'(fault_cause), cause_of(3));
    flt_raw = '0;
    tick(2);
    chk("R7 clock runs", card_clk, 1);
    clk_in = 1'b0;
    #1;
    chk("R7 low seen", card_clk, 0);
    tick(1);
    chk("R9 async sig low", sig_en, 0);
    chk("R9 async vcc on", vcc_en, 1);
    tick(1);
    chk("R9 async vcc off", vcc_en, 0);
    vcc_sel = 2'b00;
    tick(1);

    // R6 / R7: command off, async clock stuck high
    vcc_sel = 2'b01; clk_in = 1'b1; host_rst = 1'b1;
    tick(2);
    chk("R11 rst passes", card_rst, 1);
    vcc_sel = 2'b00;
    tick(1);
    chk("R6 rst low on off", card_rst, 0);
    chk("R7 clk still high", card_clk, 1);
    tick(TMO - 1);
    chk("R7 before timeout", card_clk, 1);
    tick(1);
    chk("R7 forced low", card_clk, 0);
    chk("R9 sig low off", sig_en, 0);
    chk("R9 vcc on off", vcc_en, 1);
    tick(1);
    chk("R9 vcc off off", vcc_en, 0);

    // R4: removal during session, then power with no card
    vcc_sel = 2'b01;
    tick(2);
    chk("R11 powered", vcc_en, 1);
    card_present = 1'b0;
    tick(1);
    chk("R4 removal", st_fault, 1);
    chk("R4 cause", int'(fault_cause), cause_of(6));
    chk("R6 removal rst", card_rst, 0);
    clk_in = 1'b0;
    tick(3);
    chk("R4 powered down", vcc_en, 0);
    vcc_sel = 2'b00;
    tick(2);
    vcc_sel = 2'b01;
    tick(1);
    chk("R4 no power", vcc_en, 0);
    chk("R4 empty cause", int'(fault_cause), cause_of(6));
    tick(2);
    chk("R4 stays off", vcc_en, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule